// File: doc/BRIEF.md
# Machine-Mode Signal Source Selector

This block decides where each bunch-clock and orbit output of a timing receiver takes its signal from. The choice can be made by hand: software writes a source set and the block applies it. The choice can also be made automatically from the accelerator's machine mode. A 4-bit machine-mode code arrives with a one-cycle strobe. A programmable map sorts every code into "run" or "no run". The block then applies either the shared "no run" source set or the "run" source set of the active automatic configuration. There are three automatic configurations.

A source set is one 16-bit word. It holds the main bunch-clock choice (BC1, BC2, BCref or internal), an external/internal choice for each of the three bunch-clock channels and each of the two orbit channels, and the main orbit choice (orbit 1, orbit 2 or internal counter). The select outputs are registered and feed the clock and orbit multiplexers, which sit outside this block. The mode and configuration registers are held in three copies and read through a majority vote. Any disagreement between the copies sets a sticky error flag.

Top module: `mm_src_sel`

## Requirements
- R1: After synchronous reset every output selects its internal source: main_bc_sel=3, bc_ch_int=3'b111, orb_ch_int=2'b11, main_orb_sel=2. The run state is "no run" and cfg_err=0.
- R2: With mode register (address 0, bits 1:0) at 0 (manual), the outputs follow the manual set (address 2). They ignore every machine-mode strobe.
- R3: The run map (address 1) classifies a strobed code n as "run" when bit n is 1 and as "no run" otherwise. This covers codes 0 and 15.
- R4: With mode 1, 2 or 3, the outputs follow the "no run" set (address 3) in "no run". In "run" they follow run set 1, 2 or 3 (addresses 4, 5, 6 respectively).
- R5: The run state changes only on a cycle with mm_valid high. Changing the map or mm_code without the strobe leaves the outputs unchanged.
- R6: A configuration write or a strobe sampled at one rising edge reaches the outputs at the following rising edge. The outputs hold when neither occurs.
- R7: Source-set field layout: bits 1:0 main bunch clock (0 BC1, 1 BC2, 2 BCref, 3 internal); bits 3:2, 5:4 and 7:6 the BC1, BC2 and BCref channels; bits 9:8 and 11:10 the orbit 1 and orbit 2 channels; bits 13:12 main orbit (0 orbit 1, 1 orbit 2, 2 internal); bits 15:14 unused. Channel code 0 means external and 1 means internal. Each channel output bit is 1 for internal.
- R8: Unused codes fall back to internal. Channel codes 2 and 3 act as internal. Main-orbit code 3 acts as 2.
- R9: A corrupted single copy of a configuration register does not change the outputs. Any copy mismatch sets cfg_err, which stays set until reset, even after a rewrite repairs the copies.
- R10: A write to address 7 changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| mm_valid | input | 1 | Machine-mode update strobe |
| mm_code | input | 4 | Machine-mode code |
| main_bc_sel | output | 2 | Main bunch-clock source select |
| bc_ch_int | output | 3 | Per bunch-clock channel internal select (bit0 BC1, bit1 BC2, bit2 BCref) |
| orb_ch_int | output | 2 | Per orbit channel internal select (bit0 orbit 1, bit1 orbit 2) |
| main_orb_sel | output | 2 | Main orbit source select |
| cfg_err | output | 1 | Sticky copy-mismatch flag |

## Verification
The hardest condition to reach from the ports is disagreement between the three register copies. A normal write always updates all three copies together. To create a mismatch, the bench forces one copy of the mode register to a different value for a single cycle and then releases it. It then checks that the voted selection is unchanged and that the error flag rises. It rewrites the register to repair the copies and confirms that the flag still holds. The second subtle case is a map or code change without a strobe. The bench holds such changes for several cycles and checks that the outputs do not move until the next strobe.

// File: rtl/mmsel_pkg.sv
package mmsel_pkg;
    localparam int MM_W       = 4;
    localparam int NUM_MM     = 1 << MM_W;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 3;
    localparam int NUM_REG    = 7;
    localparam int NUM_COPY   = 3;
    localparam int NUM_BC_CH  = 3;
    localparam int NUM_ORB_CH = 2;
    localparam int SEL_W      = 2;
    localparam int CFG_W      = NUM_REG * DATA_W;

    localparam int A_MODE   = 0;
    localparam int A_MAP    = 1;
    localparam int A_MANUAL = 2;
    localparam int A_NORUN  = 3;

    localparam logic [SEL_W-1:0] CH_EXT = 2'd0;

    typedef enum logic [1:0] {OP_MANUAL, OP_AUTO1, OP_AUTO2, OP_AUTO3} op_mode_e;
    typedef enum logic [1:0] {MBC_BC1, MBC_BC2, MBC_BCREF, MBC_INT} main_bc_e;
    typedef enum logic [1:0] {MORB_ORB1, MORB_ORB2, MORB_INT, MORB_SPARE} main_orb_e;

    typedef struct packed {
        logic [1:0]                       spare;
        logic [SEL_W-1:0]                 main_orb;
        logic [NUM_ORB_CH-1:0][SEL_W-1:0] orb_ch;
        logic [NUM_BC_CH-1:0][SEL_W-1:0]  bc_ch;
        logic [SEL_W-1:0]                 main_bc;
    } src_set_t;

    typedef struct packed {
        main_bc_e              main_bc;
        logic [NUM_BC_CH-1:0]  bc_int;
        logic [NUM_ORB_CH-1:0] orb_int;
        main_orb_e             main_orb;
    } sel_out_t;

    localparam logic [DATA_W-1:0] SET_ALL_INT = 16'h2557;

    function automatic logic [DATA_W-1:0] reg_reset(input int r);
        return (r >= A_MANUAL) ? SET_ALL_INT : '0;
    endfunction

    function automatic sel_out_t normalize(input src_set_t s);
        sel_out_t o;
        o.main_bc = main_bc_e'(s.main_bc);
        for (int i = 0; i < NUM_BC_CH; i++)
            o.bc_int[i] = (s.bc_ch[i] != CH_EXT);
        for (int i = 0; i < NUM_ORB_CH; i++)
            o.orb_int[i] = (s.orb_ch[i] != CH_EXT);
        o.main_orb = (main_orb_e'(s.main_orb) == MORB_SPARE) ? MORB_INT
                                                             : main_orb_e'(s.main_orb);
        return o;
    endfunction
endpackage

// File: rtl/mmsel_cfg_bank.sv
module mmsel_cfg_bank
    import mmsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [CFG_W-1:0]  q
);
    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
        logic [DATA_W-1:0] val;
        always_ff @(posedge clk) begin
            if (rst)
                val <= reg_reset(r);
            else if (we && addr == ADDR_W'(r))
                val <= wdata;
        end
        assign q[r*DATA_W +: DATA_W] = val;
    end
endmodule

// File: rtl/mmsel_vote.sv
module mmsel_vote #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] v,
    output logic         mismatch
);
    assign v        = (a & b) | (a & c) | (b & c);
    assign mismatch = (a != b) || (b != c);
endmodule

// File: rtl/mmsel_decide.sv
module mmsel_decide
    import mmsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mm_valid,
    input  logic [MM_W-1:0]  mm_code,
    input  logic [CFG_W-1:0] cfg,
    output logic             run_st,
    output sel_out_t         sel
);
    op_mode_e          op;
    logic [NUM_MM-1:0] run_map;
    src_set_t          chosen;

    assign op      = op_mode_e'(cfg[A_MODE*DATA_W +: 2]);
    assign run_map = cfg[A_MAP*DATA_W +: NUM_MM];

    always_comb begin
        if (op == OP_MANUAL)
            chosen = src_set_t'(cfg[A_MANUAL*DATA_W +: DATA_W]);
        else if (!run_st)
            chosen = src_set_t'(cfg[A_NORUN*DATA_W +: DATA_W]);
        else
            chosen = src_set_t'(cfg[(A_NORUN + int'(op))*DATA_W +: DATA_W]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            run_st <= 1'b0;
        else if (mm_valid)
            run_st <= run_map[mm_code];
    end

    always_ff @(posedge clk) begin
        if (rst)
            sel <= normalize(src_set_t'(SET_ALL_INT));
        else
            sel <= normalize(chosen);
    end
endmodule

// File: rtl/mm_src_sel.sv
module mm_src_sel
    import mmsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              mm_valid,
    input  logic [MM_W-1:0]   mm_code,
    output logic [SEL_W-1:0]  main_bc_sel,
    output logic [NUM_BC_CH-1:0]  bc_ch_int,
    output logic [NUM_ORB_CH-1:0] orb_ch_int,
    output logic [SEL_W-1:0]  main_orb_sel,
    output logic              cfg_err
);
    logic [CFG_W-1:0] copy_q [NUM_COPY];
    logic [CFG_W-1:0] cfg_v;
    logic             copy_mis;
    logic             run_st;
    sel_out_t         sel;

    for (genvar k = 0; k < NUM_COPY; k++) begin : g_copy
        mmsel_cfg_bank u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (cfg_we),
            .addr  (cfg_addr),
            .wdata (cfg_wdata),
            .q     (copy_q[k])
        );
    end

    mmsel_vote #(.W(CFG_W)) u_vote (
        .a        (copy_q[0]),
        .b        (copy_q[1]),
        .c        (copy_q[2]),
        .v        (cfg_v),
        .mismatch (copy_mis)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cfg_err <= 1'b0;
        else if (copy_mis)
            cfg_err <= 1'b1;
    end

    mmsel_decide u_decide (
        .clk      (clk),
        .rst      (rst),
        .mm_valid (mm_valid),
        .mm_code  (mm_code),
        .cfg      (cfg_v),
        .run_st   (run_st),
        .sel      (sel)
    );

    assign main_bc_sel  = sel.main_bc;
    assign bc_ch_int    = sel.bc_int;
    assign orb_ch_int   = sel.orb_int;
    assign main_orb_sel = sel.main_orb;
endmodule

// File: rtl/mmsel_chk.sv
module mmsel_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_we,
    input logic       mm_valid,
    input logic       run_st,
    input logic [1:0] main_bc_sel,
    input logic [2:0] bc_ch_int,
    input logic [1:0] orb_ch_int,
    input logic [1:0] main_orb_sel,
    input logic       cfg_err
);
    logic [8:0] outs;
    assign outs = {main_bc_sel, bc_ch_int, orb_ch_int, main_orb_sel};

    AST_ORB_FALLBACK: assert property (@(posedge clk) disable iff (rst)
        main_orb_sel != 2'd3);  // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);  // R9

    AST_RUN_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        !mm_valid |=> $stable(run_st));  // R5

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cfg_we && !mm_valid && $past(!cfg_we) && $past(!mm_valid)) |=> $stable(outs));  // R6
endmodule

bind mm_src_sel mmsel_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .mm_valid     (mm_valid),
    .run_st       (run_st),
    .main_bc_sel  (main_bc_sel),
    .bc_ch_int    (bc_ch_int),
    .orb_ch_int   (orb_ch_int),
    .main_orb_sel (main_orb_sel),
    .cfg_err      (cfg_err)
);

// File: tb/mm_src_sel_bench.sv
module mm_src_sel_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        mm_valid = 1'b0;
    logic [3:0]  mm_code = '0;
    logic [1:0]  main_bc_sel;
    logic [2:0]  bc_ch_int;
    logic [1:0]  orb_ch_int;
    logic [1:0]  main_orb_sel;
    logic        cfg_err;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    localparam logic [8:0]  OUT_RST = 9'b11_111_11_10;
    localparam logic [15:0] S_NR = 16'h1002, S_R1 = 16'h0005, S_R2 = 16'h2100, S_R3 = 16'h1043;

    always #2.5 clk = ~clk;

    mm_src_sel u_mm_src_sel (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .mm_valid(mm_valid), .mm_code(mm_code), .main_bc_sel(main_bc_sel),
        .bc_ch_int(bc_ch_int), .orb_ch_int(orb_ch_int), .main_orb_sel(main_orb_sel),
        .cfg_err(cfg_err)
    );

    // Expected outputs from a source-set word, per the field layout of R7 and fallback of R8.
    function automatic logic [8:0] exp_of(input logic [15:0] s);
        logic [1:0] morb;
        morb = (s[13:12] == 2'd3) ? 2'd2 : s[13:12];
        return {s[1:0], s[7:6] != 0, s[5:4] != 0, s[3:2] != 0,
                s[11:10] != 0, s[9:8] != 0, morb};
    endfunction

    function automatic logic [8:0] outs();
        return {main_bc_sel, bc_ch_int, orb_ch_int, main_orb_sel};
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] expv);
        vectors++;
        if (got !== expv) begin
            misses++;
            $display("FAIL %s: got %h expected %h", req, got, expv);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic strobe(input logic [3:0] code);
        @(negedge clk);
        mm_valid = 1'b1; mm_code = code;
        @(negedge clk);
        mm_valid = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 reset outputs", 16'(outs()), 16'(OUT_RST));
        check("R1 reset err", 16'(cfg_err), 16'd0);
    endtask

    task automatic t_manual();
        wr(3'd2, 16'h0000); settle();
        check("R2 manual all external", 16'(outs()), 16'(exp_of(16'h0000)));
        wr(3'd1, 16'hFFFF);
        strobe(4'd3); settle();
        check("R2 manual ignores strobe", 16'(outs()), 16'(exp_of(16'h0000)));
        wr(3'd2, S_R3); settle();
        check("R2 manual new set", 16'(outs()), 16'(exp_of(S_R3)));
    endtask

    task automatic t_layout();
        logic [15:0] pats [4] = '{16'h1000, 16'h0400, 16'h0030, 16'h0102};
        foreach (pats[i]) begin
            wr(3'd2, pats[i]); settle();
            check("R7 field layout", 16'(outs()), 16'(exp_of(pats[i])));
        end
    endtask

    task automatic t_fallback();
        wr(3'd2, 16'h3339); settle();
        check("R8 unused codes to internal", 16'(outs()), 16'(9'b01_011_01_10));
    endtask

    task automatic t_auto();
        wr(3'd1, 16'h8020);
        wr(3'd3, S_NR); wr(3'd4, S_R1); wr(3'd5, S_R2); wr(3'd6, S_R3);
        wr(3'd0, 16'd1);
        strobe(4'd4); settle();
        check("R4 auto1 no run", 16'(outs()), 16'(exp_of(S_NR)));
        strobe(4'd5); settle();
        check("R3 code 5 is run, R4 auto1 run set", 16'(outs()), 16'(exp_of(S_R1)));
        strobe(4'd0); settle();
        check("R3 code 0 no run", 16'(outs()), 16'(exp_of(S_NR)));
        strobe(4'd15); settle();
        check("R3 code 15 run", 16'(outs()), 16'(exp_of(S_R1)));
        wr(3'd0, 16'd2); settle();
        check("R4 auto2 run set", 16'(outs()), 16'(exp_of(S_R2)));
        wr(3'd0, 16'd3); settle();
        check("R4 auto3 run set", 16'(outs()), 16'(exp_of(S_R3)));
        strobe(4'd14); settle();
        check("R4 auto3 no run", 16'(outs()), 16'(exp_of(S_NR)));
    endtask

    task automatic t_gate();
        wr(3'd0, 16'd1);
        strobe(4'd5); settle();
        check("R5 run before gate", 16'(outs()), 16'(exp_of(S_R1)));
        wr(3'd1, 16'h0000);
        repeat (3) settle();
        check("R5 map write without strobe", 16'(outs()), 16'(exp_of(S_R1)));
        @(negedge clk); mm_code = 4'd4;
        repeat (4) settle();
        check("R5 code change without strobe", 16'(outs()), 16'(exp_of(S_R1)));
        strobe(4'd5); settle();
        check("R5 strobe applies new map", 16'(outs()), 16'(exp_of(S_NR)));
        wr(3'd1, 16'h8020); settle();
    endtask

    task automatic t_latency();
        @(negedge clk); mm_valid = 1'b1; mm_code = 4'd5;
        @(negedge clk); mm_valid = 1'b0;
        check("R6 strobe one edge later old", 16'(outs()), 16'(exp_of(S_NR)));
        @(negedge clk);
        check("R6 strobe two edges later new", 16'(outs()), 16'(exp_of(S_R1)));
        wr(3'd4, 16'h0000);
        check("R6 write one edge later old", 16'(outs()), 16'(exp_of(S_R1)));
        @(negedge clk);
        check("R6 write two edges later new", 16'(outs()), 16'(exp_of(16'h0000)));
    endtask

    task automatic t_bad_addr();
        wr(3'd7, 16'h0003);
        repeat (3) settle();
        check("R10 address 7 ignored", 16'(outs()), 16'(exp_of(16'h0000)));
        strobe(4'd4); settle();
        check("R10 mode still auto1", 16'(outs()), 16'(exp_of(S_NR)));
    endtask

    task automatic t_tmr();
        @(negedge clk);
        force u_mm_src_sel.g_copy[1].u_bank.g_reg[0].val = 16'h0000;
        @(negedge clk);
        release u_mm_src_sel.g_copy[1].u_bank.g_reg[0].val;
        settle();
        check("R9 vote masks corrupt copy", 16'(outs()), 16'(exp_of(S_NR)));
        check("R9 mismatch flagged", 16'(cfg_err), 16'd1);
        wr(3'd0, 16'd1);
        repeat (2) settle();
        check("R9 flag sticky after repair", 16'(cfg_err), 16'd1);
        do_reset();
        check("R1 reset clears flag", 16'(cfg_err), 16'd0);
        check("R1 reset outputs again", 16'(outs()), 16'(OUT_RST));
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        do_reset();
        t_reset();
        t_manual();
        t_layout();
        t_fallback();
        t_auto();
        t_gate();
        t_latency();
        t_bad_addr();
        t_tmr();
        report();
    end
endmodule